// File: doc/BRIEF.md
# Receive Gain Vector Distributor

This block turns one coarse receive-gain request into settings for five coarse gain stages of a receive chain: a front low-noise amplifier, a quadrature mixer and three variable amplifiers. Every stage has the same 6 dB step and a 2-bit step code. The request counts 6 dB units from 0 to 15. These units are filled into the stages in a fixed order, and each stage saturates before the next one starts. The request arrives as a parallel word with a valid strobe from a serial-to-parallel front end that is separate from the configuration path.

When a stage code changes, that stage alone gets a one-cycle offset-correction pulse. A busy flag then stays high for a programmable settling count. A request that arrives while the flag is high is held and applied once settling ends. A separate fine code for the output buffer is loaded from a configuration write and lies on a 0.76 dB grid.

Top module: `rxg_vector_dist`

## Requirements
- R1: After reset all stage codes are 0, no correction pulse is active, busy is low and the fine code is 2, which stands for 0 dB.
- R2: Stage k drives stage_code[2k+1:2k], with k=0 the front amplifier, k=1 the mixer and k=2..4 the three variable amplifiers. Code n means n·6 dB above the stage's minimum gain. For an applied unit count U, code_k = min(3, max(0, U − 3·(4−k))).
- R3: Units fill the last variable amplifier first, then the middle one, then the first one, then the mixer, and the front amplifier last. A stage is nonzero only if the next stage in that order is at code 3.
- R4: A request above 15 is applied as 15.
- R5: In the cycle new codes appear, stage_cal[k] pulses for exactly that cycle for every stage whose code changed, and for no other stage. A code never changes without its pulse.
- R6: A request that produces the codes already in place raises no pulse and leaves busy low.
- R7: After a change, busy is high during the pulse cycle and for settle_cycles further cycles, which is settle_cycles+1 cycles in all. A pulse never occurs while busy is low.
- R8: A request accepted while busy does not alter the codes. It is held, a later one replaces it, and it is applied on the clock edge that ends settling.
- R9: A request presented in the last busy cycle takes precedence over an older held request and is applied on that same edge.
- R10: A fine-code write loads buf_fine on the next edge. Values above 10 are clamped to 10, each step is 0.76 dB, and code 2 is 0 dB. A write may occur while busy, and it never causes a correction pulse or changes a stage code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Gain request strobe |
| req_units | input | 5 | Requested coarse gain in 6 dB units |
| settle_cycles | input | 8 | Settling cycles after a correction pulse |
| fine_we | input | 1 | Fine code write strobe |
| fine_code | input | 4 | Fine code write value |
| stage_code | output | 10 | Five packed 2-bit stage step codes |
| stage_cal | output | 5 | Per-stage offset-correction pulses |
| busy | output | 1 | Correction settling in progress |
| buf_fine | output | 4 | Output buffer fine gain code |

## Verification
Two functions can land on the same clock edge: the end of a settling window, which releases a held request, and a new request strobe. The bench holds one request during settling and then presents another exactly in the last busy cycle. It expects the newer request's codes and the pulse mask computed against the codes in place, and it checks that the older value never appears. The bench also loads a fine code during settling to confirm that the fine path and the correction path do not interact.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
   localparam int CODE_W   = 2;
   localparam int STEP_MAX = (1 << CODE_W) - 1;

   typedef logic [CODE_W-1:0] step_t;

   // Saturate a signed unit remainder into one stage's step range
   function automatic step_t sat_step(input int rem);
      if (rem <= 0)
         return step_t'(0);
      else if (rem >= STEP_MAX)
         return step_t'(STEP_MAX);
      else
         return step_t'(rem);
   endfunction
endpackage

// File: rtl/rxg_clamp.sv
module rxg_clamp #(
   parameter int IN_W  = 5,
   parameter int OUT_W = 4,
   parameter int MAXV  = 15
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   localparam longint IN_TOP = (longint'(1) << IN_W) - 1;

   generate
      if (IN_TOP > MAXV) begin : g_cmp
         always_comb begin
            if (din > IN_W'(MAXV))
               dout = OUT_W'(MAXV);
            else
               dout = OUT_W'(din);
         end
      end else begin : g_pass
         assign dout = OUT_W'(din);
      end
   endgenerate
endmodule

// File: rtl/rxg_map.sv
module rxg_map
   import rxg_pkg::*;
#(
   parameter int NSTAGE = 5,
   parameter int UNIT_W = 4
) (
   input  logic [UNIT_W-1:0]        units,
   output logic [NSTAGE*CODE_W-1:0] codes
);
   generate
      for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
         // Stages with a higher index are filled earlier
         localparam int BASE = STEP_MAX * (NSTAGE - 1 - k);
         always_comb begin
            codes[k*CODE_W +: CODE_W] = sat_step(int'(units) - BASE);
         end
      end
   endgenerate
endmodule

// File: rtl/rxg_seq.sv
module rxg_seq
   import rxg_pkg::*;
#(
   parameter int NSTAGE   = 5,
   parameter int UNIT_W   = 4,
   parameter int SETTLE_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [UNIT_W-1:0]          req_units,
   input  logic [SETTLE_W-1:0]        settle_cycles,
   output logic [UNIT_W-1:0]          cand_units,
   input  logic [NSTAGE*CODE_W-1:0]   cand_codes,
   output logic [NSTAGE*CODE_W-1:0]   codes_q,
   output logic [NSTAGE-1:0]          cal_q,
   output logic                       busy_q
);
   logic [SETTLE_W-1:0] cnt_q;
   logic                pend_v_q;
   logic [UNIT_W-1:0]   pend_u_q;
   logic                fin;
   logic                apply_go;
   logic [NSTAGE-1:0]   chg;

   assign fin        = busy_q && (cnt_q == '0);
   assign apply_go   = (!busy_q && req_valid) || (fin && (req_valid || pend_v_q));
   assign cand_units = req_valid ? req_units : pend_u_q;

   generate
      for (genvar k = 0; k < NSTAGE; k++) begin : g_chg
         assign chg[k] = |(cand_codes[k*CODE_W +: CODE_W] ^ codes_q[k*CODE_W +: CODE_W]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         codes_q  <= '0;
         cal_q    <= '0;
         busy_q   <= 1'b0;
         cnt_q    <= '0;
         pend_v_q <= 1'b0;
         pend_u_q <= '0;
      end else begin
         cal_q <= '0;
         if (apply_go) begin
            pend_v_q <= 1'b0;
            if (|chg) begin
               codes_q <= cand_codes;
               cal_q   <= chg;
               busy_q  <= 1'b1;
               cnt_q   <= settle_cycles;
            end else begin
               busy_q  <= 1'b0;
            end
         end else if (busy_q) begin
            if (fin)
               busy_q <= 1'b0;
            else
               cnt_q <= cnt_q - 1'b1;
            if (req_valid) begin
               pend_v_q <= 1'b1;
               pend_u_q <= req_units;
            end
         end
      end
   end
endmodule

// File: rtl/rxg_fine.sv
module rxg_fine #(
   parameter int FINE_W   = 4,
   parameter int FINE_MAX = 10,
   parameter int FINE_RST = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [FINE_W-1:0] din,
   output logic [FINE_W-1:0] dout
);
   logic [FINE_W-1:0] lim;

   rxg_clamp #(.IN_W(FINE_W), .OUT_W(FINE_W), .MAXV(FINE_MAX)) u_lim (
      .din  (din),
      .dout (lim)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dout <= FINE_W'(FINE_RST);
      else if (we)
         dout <= lim;
   end
endmodule

// File: rtl/rxg_vector_dist.sv
module rxg_vector_dist
   import rxg_pkg::*;
#(
   parameter int NSTAGE   = 5,
   parameter int REQ_W    = 5,
   parameter int SETTLE_W = 8,
   parameter int FINE_W   = 4,
   parameter int FINE_MAX = 10,
   parameter int FINE_RST = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [REQ_W-1:0]          req_units,
   input  logic [SETTLE_W-1:0]       settle_cycles,
   input  logic                      fine_we,
   input  logic [FINE_W-1:0]         fine_code,
   output logic [NSTAGE*CODE_W-1:0]  stage_code,
   output logic [NSTAGE-1:0]         stage_cal,
   output logic                      busy,
   output logic [FINE_W-1:0]         buf_fine
);
   localparam int UNIT_MAX = STEP_MAX * NSTAGE;
   localparam int UNIT_W   = $clog2(UNIT_MAX + 1);

   generate
      if (NSTAGE < 1 || NSTAGE > 8) begin : g_bad_nstage
         $error("NSTAGE out of range");
      end
      if (SETTLE_W < 1) begin : g_bad_settle
         $error("SETTLE_W must be positive");
      end
      if (FINE_MAX >= (1 << FINE_W) || FINE_RST > FINE_MAX) begin : g_bad_fine
         $error("fine code limits do not fit FINE_W");
      end
   endgenerate

   logic [UNIT_W-1:0]        req_lim;
   logic [UNIT_W-1:0]        cand_units;
   logic [NSTAGE*CODE_W-1:0] cand_codes;

   rxg_clamp #(.IN_W(REQ_W), .OUT_W(UNIT_W), .MAXV(UNIT_MAX)) u_clamp (
      .din  (req_units),
      .dout (req_lim)
   );

   rxg_map #(.NSTAGE(NSTAGE), .UNIT_W(UNIT_W)) u_map (
      .units (cand_units),
      .codes (cand_codes)
   );

   rxg_seq #(.NSTAGE(NSTAGE), .UNIT_W(UNIT_W), .SETTLE_W(SETTLE_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_units     (req_lim),
      .settle_cycles (settle_cycles),
      .cand_units    (cand_units),
      .cand_codes    (cand_codes),
      .codes_q       (stage_code),
      .cal_q         (stage_cal),
      .busy_q        (busy)
   );

   rxg_fine #(.FINE_W(FINE_W), .FINE_MAX(FINE_MAX), .FINE_RST(FINE_RST)) u_fine (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (fine_we),
      .din   (fine_code),
      .dout  (buf_fine)
   );
endmodule

// File: rtl/rxg_chk.sv
module rxg_chk #(
   parameter int NSTAGE   = 5,
   parameter int FINE_W   = 4,
   parameter int FINE_MAX = 10
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NSTAGE*2-1:0]   stage_code,
   input logic [NSTAGE-1:0]     stage_cal,
   input logic                  busy,
   input logic [FINE_W-1:0]     buf_fine
);
   generate
      for (genvar k = 0; k < NSTAGE; k++) begin : g_st
         a_r5_cal_on_change: assert property (@(posedge clk) disable iff (!rst_n)
            stage_cal[k] |-> (stage_code[2*k +: 2] != $past(stage_code[2*k +: 2])));
         a_r5_change_has_cal: assert property (@(posedge clk) disable iff (!rst_n)
            (stage_code[2*k +: 2] != $past(stage_code[2*k +: 2])) |-> stage_cal[k]);
         if (k < NSTAGE - 1) begin : g_ord
            a_r3_fill_order: assert property (@(posedge clk) disable iff (!rst_n)
               (stage_code[2*k +: 2] != 2'd0) |-> (stage_code[2*(k+1) +: 2] == 2'd3));
         end
      end
   endgenerate

   a_r7_cal_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (|stage_cal) |-> busy);

   a_r10_fine_limit: assert property (@(posedge clk) disable iff (!rst_n)
      buf_fine <= FINE_W'(FINE_MAX));
endmodule

bind rxg_vector_dist rxg_chk #(.NSTAGE(NSTAGE), .FINE_W(FINE_W), .FINE_MAX(FINE_MAX)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stage_code (stage_code),
   .stage_cal  (stage_cal),
   .busy       (busy),
   .buf_fine   (buf_fine)
);

// File: tb/tb_rxg_vector_dist.sv
`timescale 1ns/1ps
module tb_rxg_vector_dist;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [4:0] req_units = '0;
   logic [7:0] settle_cycles = '0;
   logic       fine_we = 1'b0;
   logic [3:0] fine_code = '0;
   logic [9:0] stage_code;
   logic [4:0] stage_cal;
   logic       busy;
   logic [3:0] buf_fine;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rxg_vector_dist dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_units(req_units),
      .settle_cycles(settle_cycles), .fine_we(fine_we), .fine_code(fine_code),
      .stage_code(stage_code), .stage_cal(stage_cal), .busy(busy), .buf_fine(buf_fine)
   );

   function automatic logic [9:0] exp_vec(input int u);
      logic [9:0] v;
      int uc;
      int r;
      uc = (u > 15) ? 15 : u;
      for (int k = 0; k < 5; k++) begin
         r = uc - 3 * (4 - k);
         if (r < 0) r = 0;
         if (r > 3) r = 3;
         v[2*k +: 2] = 2'(r);
      end
      return v;
   endfunction

   function automatic logic [4:0] exp_mask(input logic [9:0] a, input logic [9:0] b);
      logic [4:0] m;
      for (int k = 0; k < 5; k++) m[k] = (a[2*k +: 2] != b[2*k +: 2]);
      return m;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic req(input int u);
      @(negedge clk);
      req_valid = 1'b1;
      req_units = 5'(u);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 1000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_up();
   end

   initial begin
      logic [9:0] prev;
      int n;
      repeat (3) @(negedge clk);
      // R1: reset state while reset is held and just after release
      chk(stage_code == 10'd0 && stage_cal == 5'd0 && !busy, "R1", int'(stage_code), 0);
      chk(buf_fine == 4'd2, "R1 fine", int'(buf_fine), 2);
      rst_n = 1'b1;
      @(negedge clk);
      chk(stage_code == 10'd0 && !busy, "R1 post", int'(stage_code), 0);

      // R2 R3 R4 R5 R6 R7: sweep all transitions for two settle lengths
      for (int s = 0; s < 3; s += 2) begin
         settle_cycles = 8'(s);
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 18; b++) begin
               req(a);
               wait_idle();
               prev = stage_code;
               req(b);
               chk(stage_code == exp_vec(b), "R2 R4 codes", int'(stage_code), int'(exp_vec(b)));
               chk(stage_cal == exp_mask(prev, exp_vec(b)), "R5 mask",
                   int'(stage_cal), int'(exp_mask(prev, exp_vec(b))));
               n = 0;
               while (busy && n < 100) begin
                  n++;
                  @(negedge clk);
               end
               if (exp_mask(prev, exp_vec(b)) == 5'd0)
                  chk(n == 0, "R6 no busy", n, 0);
               else
                  chk(n == s + 1, "R7 busy length", n, s + 1);
               chk(stage_cal == 5'd0, "R5 single pulse", int'(stage_cal), 0);
            end
         end
      end

      // R8: held requests, the latest wins, codes frozen while busy
      settle_cycles = 8'd4;
      req(0);
      wait_idle();
      req(6);
      req_valid = 1'b1;
      req_units = 5'd9;
      @(negedge clk);
      chk(stage_code == exp_vec(6), "R8 frozen", int'(stage_code), int'(exp_vec(6)));
      req_units = 5'd12;
      @(negedge clk);
      req_valid = 1'b0;
      chk(stage_code == exp_vec(6), "R8 frozen2", int'(stage_code), int'(exp_vec(6)));
      n = 0;
      while (stage_cal == 5'd0 && n < 50) begin
         @(negedge clk);
         n++;
         if (stage_cal == 5'd0) chk(busy, "R8 busy held", int'(busy), 1);
      end
      chk(n == 3, "R8 apply timing", n, 3);
      chk(stage_code == exp_vec(12), "R8 latest", int'(stage_code), int'(exp_vec(12)));
      chk(stage_cal == exp_mask(exp_vec(6), exp_vec(12)), "R8 mask",
          int'(stage_cal), int'(exp_mask(exp_vec(6), exp_vec(12))));
      wait_idle();

      // R9: new request in last busy cycle overrides an older held one
      settle_cycles = 8'd3;
      req(0);
      wait_idle();
      req(15);
      req_valid = 1'b1;
      req_units = 5'd9;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(busy && stage_cal == 5'd0, "R9 last cycle busy", int'(busy), 1);
      req_valid = 1'b1;
      req_units = 5'd4;
      @(negedge clk);
      req_valid = 1'b0;
      chk(stage_code == exp_vec(4), "R9 newer wins", int'(stage_code), int'(exp_vec(4)));
      chk(stage_cal == exp_mask(exp_vec(15), exp_vec(4)), "R9 mask",
          int'(stage_cal), int'(exp_mask(exp_vec(15), exp_vec(4))));
      wait_idle();
      repeat (3) @(negedge clk);
      chk(stage_code == exp_vec(4), "R9 old dropped", int'(stage_code), int'(exp_vec(4)));

      // R10: fine code sweep with clamp
      for (int f = 0; f < 16; f++) begin
         @(negedge clk);
         fine_we = 1'b1;
         fine_code = 4'(f);
         @(negedge clk);
         fine_we = 1'b0;
         chk(int'(buf_fine) == ((f > 10) ? 10 : f), "R10 fine", int'(buf_fine), (f > 10) ? 10 : f);
         chk(stage_cal == 5'd0 && !busy, "R10 no pulse", int'(stage_cal), 0);
      end
      // R10: write during settling does not disturb codes
      settle_cycles = 8'd5;
      req(8);
      fine_we = 1'b1;
      fine_code = 4'd7;
      @(negedge clk);
      fine_we = 1'b0;
      chk(buf_fine == 4'd7, "R10 busy write", int'(buf_fine), 7);
      chk(stage_cal == 5'd0 && stage_code == exp_vec(8), "R10 codes kept",
          int'(stage_code), int'(exp_vec(8)));
      wait_idle();

      finish_up();
   end
endmodule